// File: doc/BRIEF.md
# Receive Foreground Buffer Flag Controller

This block sits between an already-validated message receiver and a host register interface. Incoming messages are queued in a small first-in first-out store. The oldest entry is presented to the host as a single foreground buffer. When an entry moves into the foreground, a full flag rises. The foreground then stays frozen until the host clears that flag. Clearing the flag is the only event that lets the next queued message advance.

When a message arrives while every queue slot and the foreground are occupied, the message is discarded and an overrun flag is raised. Both flags are cleared by writing ones. A small interrupt-enable register turns each flag into a level interrupt. That register is forced to zero while the initialization handshake (request and acknowledge both high) is active. It accepts writes only when both handshake inputs are low.

Register map on `reg_addr`: 0 = flags (bit 0 full, bit 1 overrun), 1 = interrupt enable (bit 0 receive, bit 1 error), 2 = foreground message, 3 = reads zero. `reg_rdata` is registered: it shows the value at `reg_addr` as it stood just before the previous rising edge.

Top module: `rxbuf_flag_ctrl`

## Requirements
- R1: After synchronous active-high reset, both flags, the enable register and both interrupt outputs are 0, and the queue is empty.
- R2: A push into an empty block with a clear full flag is written on its edge and moves into the foreground on the next edge, where the full flag (flags bit 0) becomes 1 and address 2 reads the pushed message.
- R3: While the full flag is 1, the foreground contents do not change whatever is pushed, and queued messages reach the foreground in arrival order.
- R4: Writing 1 to flags bit 0 clears the full flag on that edge; if the queue holds entries, the next one enters the foreground on the following edge and the flag is set again; writing 0 changes nothing.
- R5: The queue holds DEPTH (default 4) entries besides the foreground; a push while the queue is full and the full flag is 1 sets the overrun flag (flags bit 1) and the message is dropped.
- R6: Writing 1 to flags bit 1 clears the overrun flag.
- R7: `irq_rx` equals full flag AND enable bit 0, and `irq_err` equals overrun flag AND enable bit 1, both updated on the same edge as the flags.
- R8: While `init_req` and `init_ack` are both 1, the enable register reads 0 and writes to it have no effect.
- R9: The enable register is written only when `init_req` and `init_ack` are both 0; with exactly one of them high it keeps its value; it can be read at any time.
- R10: Reading address 2 while the full flag is 0 returns 0 and changes no state.
- R11: A flag set event in the same cycle as a write-1 clear of that flag leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push_valid | input | 1 | A validated message is offered this cycle |
| push_data | input | DATA_W | Message payload |
| init_req | input | 1 | Initialization mode request |
| init_ack | input | 1 | Initialization mode acknowledge |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 2 | Register write data (flag or enable bits) |
| reg_rdata | output | DATA_W | Registered read data |
| irq_rx | output | 1 | Receive interrupt level |
| irq_err | output | 1 | Error (overrun) interrupt level |

## Verification
The bench fills the queue to its last slot and then pushes twice more. A design that mis-sized the queue or counted the foreground wrongly would either drop a valid message or keep one that should be lost, and the drained sequence would then differ. It clears the full flag and samples the interrupt one cycle later and again two cycles later. This catches a design that advances the queue without the clear, or in the same cycle as it. The bench also pushes during an overrun-flag clear to expose a clear that wins over a set. It walks the initialization handshake through every combination of request and acknowledge, so a design that decoded the handshake loosely would let an enable write through or fail to zero the register.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  typedef enum logic [1:0] {
    RA_FLAGS = 2'd0,
    RA_IEN   = 2'd1,
    RA_FG    = 2'd2,
    RA_RSVD  = 2'd3
  } reg_addr_e;

  localparam int FLG_FULL = 0;
  localparam int FLG_OVR  = 1;
  localparam int IEN_RX   = 0;
  localparam int IEN_ERR  = 1;
  localparam int CTRL_W   = 2;
endpackage

// File: rtl/rxbuf_fifo.sv
module rxbuf_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     cnt_q;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  // registered read port doubles as the foreground buffer
  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_MAX);
endmodule

// File: rtl/rxbuf_w1c_flag.sv
module rxbuf_w1c_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o,
  output logic nxt_o
);
  always_comb begin
    nxt_o = flag_o;
    if (clr_i) nxt_o = 1'b0;
    if (set_i) nxt_o = 1'b1;   // set wins over a same-cycle clear
  end

  always_ff @(posedge clk) begin
    if (rst) flag_o <= 1'b0;
    else     flag_o <= nxt_o;
  end
endmodule

// File: rtl/rxbuf_ien_reg.sv
module rxbuf_ien_reg #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold_zero,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q,
  output logic [W-1:0] nxt
);
  always_comb begin
    nxt = q;
    if (wr_en)     nxt = wdata;
    if (hold_zero) nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/rxbuf_flag_ctrl.sv
module rxbuf_flag_ctrl
  import rxbuf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              init_req,
  input  logic              init_ack,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_rx,
  output logic              irq_err
);
  logic              full_q, full_d, ovr_q, ovr_d;
  logic [CTRL_W-1:0] ien_q, ien_d;
  logic [DATA_W-1:0] fg_data;
  logic              q_empty, q_full;
  logic              shift, ovr_evt, push_ok;
  logic              flag_wr, ien_wr, in_init;
  logic [DATA_W-1:0] rd_mux;

  assign shift   = !full_q && !q_empty;
  assign ovr_evt = push_valid && full_q && q_full;
  assign push_ok = push_valid && !ovr_evt;
  assign flag_wr = reg_wr && (reg_addr == RA_FLAGS);
  assign in_init = init_req && init_ack;
  assign ien_wr  = reg_wr && (reg_addr == RA_IEN) && !init_req && !init_ack;

  rxbuf_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .wr_en(push_ok), .wr_data(push_data),
    .rd_en(shift), .rd_data(fg_data),
    .empty(q_empty), .full(q_full)
  );

  rxbuf_w1c_flag u_full_flag (
    .clk(clk), .rst(rst),
    .set_i(shift), .clr_i(flag_wr && reg_wdata[FLG_FULL]),
    .flag_o(full_q), .nxt_o(full_d)
  );

  rxbuf_w1c_flag u_ovr_flag (
    .clk(clk), .rst(rst),
    .set_i(ovr_evt), .clr_i(flag_wr && reg_wdata[FLG_OVR]),
    .flag_o(ovr_q), .nxt_o(ovr_d)
  );

  rxbuf_ien_reg #(.W(CTRL_W)) u_ien (
    .clk(clk), .rst(rst),
    .hold_zero(in_init), .wr_en(ien_wr), .wdata(reg_wdata),
    .q(ien_q), .nxt(ien_d)
  );

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      RA_FLAGS: begin
        rd_mux[FLG_FULL] = full_q;
        rd_mux[FLG_OVR]  = ovr_q;
      end
      RA_IEN:  rd_mux[CTRL_W-1:0] = ien_q;
      RA_FG:   rd_mux = full_q ? fg_data : '0;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_rx    <= 1'b0;
      irq_err   <= 1'b0;
    end else begin
      reg_rdata <= rd_mux;
      irq_rx    <= full_d && ien_d[IEN_RX];
      irq_err   <= ovr_d && ien_d[IEN_ERR];
    end
  end
endmodule

// File: rtl/rxbuf_flag_ctrl_chk.sv
module rxbuf_flag_ctrl_chk
  import rxbuf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       push_valid,
  input logic                       init_req,
  input logic                       init_ack,
  input logic                       reg_wr,
  input logic [1:0]                 reg_addr,
  input logic [CTRL_W-1:0]          reg_wdata,
  input logic [DATA_W-1:0]          reg_rdata,
  input logic                       irq_rx,
  input logic                       irq_err,
  input logic                       full_q,
  input logic                       ovr_q,
  input logic [CTRL_W-1:0]          ien_q,
  input logic [DATA_W-1:0]          fg_data,
  input logic [$clog2(DEPTH+1)-1:0] fifo_cnt
);
  localparam int CW = $clog2(DEPTH + 1);

  logic clr_full;
  assign clr_full = reg_wr && (reg_addr == RA_FLAGS) && reg_wdata[FLG_FULL];

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    fifo_cnt <= CW'(DEPTH));

  p_fg_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    full_q && !clr_full |=> full_q && $stable(fg_data));

  p_drop_r5: assert property (@(posedge clk) disable iff (rst)
    push_valid && full_q && fifo_cnt == CW'(DEPTH) |=> ovr_q && $stable(fifo_cnt));

  p_irq_rx_r7: assert property (@(posedge clk) disable iff (rst)
    irq_rx == (full_q && ien_q[IEN_RX]));

  p_irq_err_r7: assert property (@(posedge clk) disable iff (rst)
    irq_err == (ovr_q && ien_q[IEN_ERR]));

  p_ien_zero_r8: assert property (@(posedge clk) disable iff (rst)
    init_req && init_ack |=> ien_q == '0);

  p_ien_locked_r9: assert property (@(posedge clk) disable iff (rst)
    init_req != init_ack |=> $stable(ien_q));

  p_fg_read_zero_r10: assert property (@(posedge clk) disable iff (rst)
    reg_addr == RA_FG && !full_q |=> reg_rdata == '0);
endmodule

bind rxbuf_flag_ctrl rxbuf_flag_ctrl_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .push_valid(push_valid),
  .init_req(init_req), .init_ack(init_ack),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .irq_rx(irq_rx), .irq_err(irq_err),
  .full_q(full_q), .ovr_q(ovr_q), .ien_q(ien_q), .fg_data(fg_data),
  .fifo_cnt(u_fifo.cnt_q)
);

// File: tb/rxbuf_flag_ctrl_tb.sv
`timescale 1ns/1ps
module rxbuf_flag_ctrl_tb;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              push_valid = 1'b0;
  logic [DATA_W-1:0] push_data = '0;
  logic              init_req = 1'b0;
  logic              init_ack = 1'b0;
  logic              reg_wr = 1'b0;
  logic [1:0]        reg_addr = 2'd0;
  logic [1:0]        reg_wdata = 2'd0;
  logic [DATA_W-1:0] reg_rdata;
  logic              irq_rx, irq_err;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rxbuf_flag_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
    .init_req(init_req), .init_ack(init_ack), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_rx(irq_rx), .irq_err(irq_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [DATA_W-1:0] d);
    push_valid = 1'b1; push_data = d;
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DATA_W-1:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] v;
    logic [DATA_W-1:0] exp_q [4];
    exp_q = '{8'h22, 8'h33, 8'h44, 8'h55};
    idle(3);
    rst = 1'b0;

    // R1 reset state
    rd(2'd0, v); chk("R1 flags", v, 0);
    rd(2'd1, v); chk("R1 ien", v, 0);
    chk("R1 irq_rx", irq_rx, 0);
    chk("R1 irq_err", irq_err, 0);
    rd(2'd2, v); chk("R10 fg empty", v, 0);

    // R2 first message reaches foreground
    push(8'h11); idle(1);
    rd(2'd0, v); chk("R2 full flag", v, 1);
    rd(2'd2, v); chk("R2 fg data", v, 8'h11);

    // R3 fill the queue, foreground frozen
    push(8'h22); push(8'h33); push(8'h44); push(8'h55);
    rd(2'd2, v); chk("R3 fg frozen", v, 8'h11);
    rd(2'd0, v); chk("R5 no overrun at capacity", v, 1);

    // R5 overrun
    push(8'h66);
    rd(2'd0, v); chk("R5 overrun flag", v, 3);

    // R7 / R9 enables
    wr(2'd1, 2'd3);
    rd(2'd1, v); chk("R9 ien write", v, 3);
    chk("R7 irq_rx", irq_rx, 1);
    chk("R7 irq_err", irq_err, 1);

    // R11 set and clear of overrun in one cycle
    push_valid = 1'b1; push_data = 8'h77;
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 2'd2;
    @(negedge clk);
    push_valid = 1'b0; reg_wr = 1'b0;
    rd(2'd0, v); chk("R11 set wins", v, 3);

    // R6 clear overrun
    wr(2'd0, 2'd2);
    chk("R7 irq_err after clear", irq_err, 0);
    rd(2'd0, v); chk("R6 overrun cleared", v, 1);

    // R4 writing zero has no effect
    wr(2'd0, 2'd0);
    rd(2'd0, v); chk("R4 write zero", v, 1);

    // R4 / R3 drain in order
    foreach (exp_q[i]) begin
      wr(2'd0, 2'd1);
      chk("R4 flag cleared on write", irq_rx, 0);
      @(negedge clk);
      chk("R4 flag set after shift", irq_rx, 1);
      rd(2'd2, v); chk("R3 order", v, exp_q[i]);
    end
    wr(2'd0, 2'd1); idle(3);
    rd(2'd0, v); chk("R5 dropped messages absent", v, 0);
    rd(2'd2, v); chk("R10 fg read when clear", v, 0);
    chk("R7 irq_rx idle", irq_rx, 0);

    // R7 sweep over enable values
    for (int en = 0; en < 4; en++) begin
      wr(2'd1, 2'(en));
      chk("R7 sweep irq_rx empty", irq_rx, 0);
      push(8'hA0 + 8'(en)); idle(1);
      chk("R7 sweep irq_rx", irq_rx, en & 1);
      chk("R7 sweep irq_err", irq_err, 0);
      rd(2'd2, v); chk("R2 sweep fg", v, 8'hA0 + en);
      wr(2'd0, 2'd1); idle(1);
    end

    // R8 / R9 initialization handshake
    init_req = 1'b1;
    wr(2'd1, 2'd0);
    rd(2'd1, v); chk("R9 locked req only", v, 3);
    init_ack = 1'b1; idle(1);
    rd(2'd1, v); chk("R8 held zero", v, 0);
    wr(2'd1, 2'd3);
    rd(2'd1, v); chk("R8 write ignored", v, 0);
    init_req = 1'b0;
    wr(2'd1, 2'd1);
    rd(2'd1, v); chk("R9 locked ack only", v, 0);
    init_ack = 1'b0;
    wr(2'd1, 2'd1);
    rd(2'd1, v); chk("R9 write after init", v, 1);

    // R10 reading foreground while clear has no side effect
    rd(2'd2, v); chk("R10 zero read", v, 0);
    rd(2'd0, v); chk("R10 flags untouched", v, 0);
    push(8'h5A); idle(1);
    rd(2'd2, v); chk("R10 later message intact", v, 8'h5A);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule